// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block is the digital controller of a dual-slope integrating converter. It repeats a measurement cycle of four windows: offset storage (auto-zero), signal integration, reference de-integration and a recovery window that returns the integrator to zero. For each window it drives the enable of the matching analog switch. All window lengths are counted in ticks of one count clock. A prescaler derives that count clock from the system clock, and its division ratio follows from a three-bit rate code, a crystal select (4 MHz or 12 MHz) and a line-frequency option (50 Hz or 60 Hz). The rate therefore changes the tick period and leaves the tick counts of each window alone.

At the last tick of signal integration the block samples the comparator. That sample becomes the sign of the result and also picks the polarity of the reference used for de-integration. During de-integration the block counts ticks until the comparator disagrees with the sampled sign, and then turns the reference off. At the close of the de-integration window it publishes a magnitude and a sign and raises an end-of-conversion strobe for one clock. If no crossing happened inside the window, the magnitude is pinned at full scale and an overrange flag is set.

Top module: `dslope_sequencer`

## Requirements
- R1: The windows run in the fixed order auto-zero, integrate, de-integrate, zero-integrate and then repeat. Exactly one window is active on any clock. `sw_az`, `sw_int` and `sw_zi` are high during their own windows. In de-integration, at most one of `sw_ref_pos`/`sw_ref_neg` is high, and never outside that window.
- R2: The windows last AZ_LEN, INT_LEN, DEINT_LEN and ZI_LEN count ticks. The defaults are 2750, 10000, 11000 and 7500, which are 8.8 %, 32 %, 35.2 % and 24 % of the cycle. The window state changes only on a clock where a tick occurs.
- R3: With `xtal_4m`=0 and `line_60hz`=0, codes 101, 100, 011, 010, 001, 000, 110 and 111 give a tick every 3, 4, 6, 12, 24, 48, 120 and 240 clocks. These correspond to 128, 96, 64, 32, 16, 8, 3.2 and 1.6 conversions per second at 12 MHz.
- R4: With `xtal_4m`=0 and `line_60hz`=1, codes 011, 010, 001, 000, 110 and 111 give 5, 10, 20, 40, 100 and 200 clocks per tick (76.8 to 1.92 per second). Codes 101 and 100 keep 3 and 4.
- R5: With `xtal_4m`=1, `line_60hz` has no effect. Codes 101, 100, 011, 010, 001, 000, 110 and 111 give 1, 2, 2, 4, 8, 16, 40 and 80 clocks per tick.
- R6: The rate inputs are taken on the clock that ends a zero-integrate window and apply to the whole next cycle. The first cycle after reset uses 48 clocks per tick.
- R7: The sign is `cmp_neg` as sampled on the last integrate tick. When the sign is 0, `sw_ref_neg` drives de-integration. When the sign is 1, `sw_ref_pos` drives it.
- R8: The magnitude is the de-integration tick index k (0 for the first tick) of the first tick at which `cmp_neg` differs from the sign. Both reference enables are low from the clock after that tick until the window ends.
- R9: If no crossing occurs by the last de-integration tick, the magnitude is DEINT_LEN (default 11000) and `overrange` is 1. Otherwise `overrange` is 0.
- R10: `eoc` is high for exactly the first clock of each zero-integrate window. `result_mag`, `result_neg` and `overrange` take their new values on that same clock and hold them until the next strobe.
- R11: While reset is asserted, `sw_az`=1, all other switch enables are 0, `eoc`=0, and the result outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (crystal rate) |
| rst_n | input | 1 | Asynchronous reset, active low |
| rate_code | input | 3 | Conversion-rate code |
| xtal_4m | input | 1 | 1: 4 MHz crystal, 0: 12 MHz crystal |
| line_60hz | input | 1 | 1: 60 Hz rejection timing, 0: 50 Hz |
| cmp_neg | input | 1 | Comparator: integrator holds negative charge |
| sw_az | output | 1 | Auto-zero switch enable |
| sw_int | output | 1 | Signal-integrate switch enable |
| sw_ref_pos | output | 1 | Positive reference switch enable |
| sw_ref_neg | output | 1 | Negative reference switch enable |
| sw_zi | output | 1 | Zero-integrate switch enable |
| result_mag | output | RES_W | Result magnitude in counts |
| result_neg | output | 1 | Result sign, 1 for negative input |
| overrange | output | 1 | Result saturated at full scale |
| eoc | output | 1 | One-clock end-of-conversion strobe |

## Verification
The bench drives a behavioural integrator that sums the input while the integrate switch is on and removes a fixed reference step while a reference switch is on. Its comparator has hysteresis, so a zero input reads positive. Inputs of 0, ±1 and small mid-range values show whether the crossing index is counted from the first tick, and whether the reference polarity follows the sampled sign. Values of 43, 44 and −50 separate the last in-range reading from saturation, in both polarities. From one cycle to the next the rate code, the crystal select and the line option are changed, including 60 Hz in 4 MHz mode. The model predicts every switch edge from its own divider table, so a wrong divider or a rate applied mid-cycle shows up on the first clock where a window boundary moves.

// File: rtl/dslope_pkg.sv
package dslope_pkg;

  typedef enum logic [1:0] {
    PH_AZ    = 2'd0,
    PH_INT   = 2'd1,
    PH_DEINT = 2'd2,
    PH_ZI    = 2'd3
  } phase_t;

  // Conversion rate in hundredths of a conversion per second, as seen at
  // the 12 MHz reference crystal; 4 MHz mode reuses the 50 Hz column except
  // for code 100.
  function automatic int unsigned rate_centi(input logic [2:0] code,
                                             input logic hz60,
                                             input logic xtal4);
    logic alt;
    int unsigned r;
    alt = hz60 && !xtal4;
    case (code)
      3'b101:  r = 12800;
      3'b100:  r = xtal4 ? 6400 : 9600;
      3'b011:  r = alt ? 7680 : 6400;
      3'b010:  r = alt ? 3840 : 3200;
      3'b001:  r = alt ? 1920 : 1600;
      3'b000:  r = alt ? 960  : 800;
      3'b110:  r = alt ? 384  : 320;
      default: r = alt ? 192  : 160;
    endcase
    return r;
  endfunction

  // Clocks per count tick: ref_div is the ratio at 8/s on the fast crystal.
  function automatic int unsigned count_divider(input logic [2:0] code,
                                                input logic hz60,
                                                input logic xtal4,
                                                input int unsigned ref_div,
                                                input int unsigned ratio);
    int unsigned d;
    d = (ref_div * 800) / rate_centi(code, hz60, xtal4);
    if (xtal4) d = d / ratio;
    return d;
  endfunction

endpackage

// File: rtl/dslope_prescaler.sv
module dslope_prescaler #(
  parameter int DIV_W     = 8,
  parameter int RESET_DIV = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] new_div,
  output logic             tick
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;

  assign tick = (cnt_q == div_q - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIV_W'(RESET_DIV);
      cnt_q <= '0;
    end else begin
      if (tick) cnt_q <= '0;
      else      cnt_q <= cnt_q + DIV_W'(1);
      if (load) div_q <= new_div;
    end
  end
endmodule

// File: rtl/dslope_phase_ctl.sv
module dslope_phase_ctl
  import dslope_pkg::*;
#(
  parameter int AZ_LEN    = 2750,
  parameter int INT_LEN   = 10000,
  parameter int DEINT_LEN = 11000,
  parameter int ZI_LEN    = 7500,
  parameter int CNT_W     = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output phase_t           phase,
  output logic [CNT_W-1:0] cnt,
  output logic             win_last
);
  phase_t           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cur_len;
  logic             at_end;

  always_comb begin
    case (phase_q)
      PH_AZ:    cur_len = CNT_W'(AZ_LEN);
      PH_INT:   cur_len = CNT_W'(INT_LEN);
      PH_DEINT: cur_len = CNT_W'(DEINT_LEN);
      default:  cur_len = CNT_W'(ZI_LEN);
    endcase
  end

  assign at_end   = (cnt_q == cur_len - CNT_W'(1));
  assign win_last = tick && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_AZ;
      cnt_q   <= '0;
    end else if (tick) begin
      if (at_end) begin
        cnt_q   <= '0;
        phase_q <= phase_t'(phase_q + 2'd1);
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign phase = phase_q;
  assign cnt   = cnt_q;
endmodule

// File: rtl/dslope_result.sv
module dslope_result #(
  parameter int CNT_W     = 14,
  parameter int RES_W     = 14,
  parameter int DEINT_LEN = 11000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             in_deint,
  input  logic             int_last,
  input  logic             deint_last,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cmp_neg,
  output logic             sign_q,
  output logic             crossed_q,
  output logic             cross_evt,
  output logic [RES_W-1:0] mag_q,
  output logic             neg_q,
  output logic             over_q,
  output logic             eoc_q
);
  logic [RES_W-1:0] cap_q;

  assign cross_evt = tick && in_deint && !crossed_q && (cmp_neg != sign_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sign_q    <= 1'b0;
      crossed_q <= 1'b0;
      cap_q     <= '0;
      mag_q     <= '0;
      neg_q     <= 1'b0;
      over_q    <= 1'b0;
      eoc_q     <= 1'b0;
    end else begin
      eoc_q <= 1'b0;
      if (int_last) begin
        sign_q    <= cmp_neg;
        crossed_q <= 1'b0;
        cap_q     <= '0;
      end
      if (cross_evt) begin
        crossed_q <= 1'b1;
        cap_q     <= RES_W'(cnt);
      end
      if (deint_last) begin
        eoc_q <= 1'b1;
        neg_q <= sign_q;
        if (cross_evt) begin
          mag_q  <= RES_W'(cnt);
          over_q <= 1'b0;
        end else if (crossed_q) begin
          mag_q  <= cap_q;
          over_q <= 1'b0;
        end else begin
          mag_q  <= RES_W'(DEINT_LEN);
          over_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dslope_sequencer.sv
module dslope_sequencer
  import dslope_pkg::*;
#(
  parameter int AZ_LEN      = 2750,
  parameter int INT_LEN     = 10000,
  parameter int DEINT_LEN   = 11000,
  parameter int ZI_LEN      = 7500,
  parameter int RES_W       = 14,
  parameter int REF_DIV     = 48,
  parameter int XTAL_RATIO  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       rate_code,
  input  logic             xtal_4m,
  input  logic             line_60hz,
  input  logic             cmp_neg,
  output logic             sw_az,
  output logic             sw_int,
  output logic             sw_ref_pos,
  output logic             sw_ref_neg,
  output logic             sw_zi,
  output logic [RES_W-1:0] result_mag,
  output logic             result_neg,
  output logic             overrange,
  output logic             eoc
);
  localparam int MAX_DIV  = (REF_DIV * 800) / 160;
  localparam int DIV_W    = $clog2(MAX_DIV + 1);
  localparam int LEN_A    = (AZ_LEN > INT_LEN) ? AZ_LEN : INT_LEN;
  localparam int LEN_B    = (DEINT_LEN > ZI_LEN) ? DEINT_LEN : ZI_LEN;
  localparam int MAX_LEN  = (LEN_A > LEN_B) ? LEN_A : LEN_B;
  localparam int CNT_W    = $clog2(MAX_LEN + 1);

  // Named internal events, observed by the bound checker.
  logic             tick;
  logic             cycle_end;
  logic             deint_win;
  logic             cross_evt;
  logic             crossed;

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic             win_last;
  logic             sign_q;
  logic [DIV_W-1:0] next_div;

  assign next_div = DIV_W'(count_divider(rate_code, line_60hz, xtal_4m,
                                         REF_DIV, XTAL_RATIO));

  dslope_prescaler #(
    .DIV_W     (DIV_W),
    .RESET_DIV (REF_DIV)
  ) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cycle_end),
    .new_div (next_div),
    .tick    (tick)
  );

  dslope_phase_ctl #(
    .AZ_LEN    (AZ_LEN),
    .INT_LEN   (INT_LEN),
    .DEINT_LEN (DEINT_LEN),
    .ZI_LEN    (ZI_LEN),
    .CNT_W     (CNT_W)
  ) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .phase    (phase),
    .cnt      (cnt),
    .win_last (win_last)
  );

  assign deint_win = (phase == PH_DEINT);
  assign cycle_end = win_last && (phase == PH_ZI);

  dslope_result #(
    .CNT_W     (CNT_W),
    .RES_W     (RES_W),
    .DEINT_LEN (DEINT_LEN)
  ) u_res (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .in_deint   (deint_win),
    .int_last   (win_last && (phase == PH_INT)),
    .deint_last (win_last && deint_win),
    .cnt        (cnt),
    .cmp_neg    (cmp_neg),
    .sign_q     (sign_q),
    .crossed_q  (crossed),
    .cross_evt  (cross_evt),
    .mag_q      (result_mag),
    .neg_q      (result_neg),
    .over_q     (overrange),
    .eoc_q      (eoc)
  );

  assign sw_az      = (phase == PH_AZ);
  assign sw_int     = (phase == PH_INT);
  assign sw_zi      = (phase == PH_ZI);
  assign sw_ref_pos = deint_win && !crossed && sign_q;
  assign sw_ref_neg = deint_win && !crossed && !sign_q;
endmodule

// File: rtl/dslope_sequencer_chk.sv
module dslope_sequencer_chk #(
  parameter int RES_W     = 14,
  parameter int DEINT_LEN = 11000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             deint_win,
  input logic             crossed,
  input logic             sw_az,
  input logic             sw_int,
  input logic             sw_ref_pos,
  input logic             sw_ref_neg,
  input logic             sw_zi,
  input logic [RES_W-1:0] result_mag,
  input logic             overrange,
  input logic             eoc
);
  assert_one_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({sw_az, sw_int, deint_win, sw_zi}));

  assert_ref_in_deint_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_ref_pos || sw_ref_neg) |-> (deint_win && !(sw_ref_pos && sw_ref_neg)));

  assert_int_after_az_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_int) |-> $past(sw_az));

  assert_az_after_zi_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_az) |-> $past(sw_zi));

  assert_move_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> $stable({sw_az, sw_int, deint_win, sw_zi}));

  assert_ref_off_after_cross_R8: assert property (@(posedge clk) disable iff (!rst_n)
    crossed |-> !(sw_ref_pos || sw_ref_neg));

  assert_over_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overrange |-> (result_mag == RES_W'(DEINT_LEN)));

  assert_mag_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    result_mag <= RES_W'(DEINT_LEN));

  assert_eoc_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> !eoc);

  assert_eoc_at_zi_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |-> $rose(sw_zi));

  assert_hold_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc |-> ($stable(result_mag) && $stable(overrange)));
endmodule

bind dslope_sequencer dslope_sequencer_chk #(
  .RES_W     (RES_W),
  .DEINT_LEN (DEINT_LEN)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .deint_win  (deint_win),
  .crossed    (crossed),
  .sw_az      (sw_az),
  .sw_int     (sw_int),
  .sw_ref_pos (sw_ref_pos),
  .sw_ref_neg (sw_ref_neg),
  .sw_zi      (sw_zi),
  .result_mag (result_mag),
  .overrange  (overrange),
  .eoc        (eoc)
);

// File: tb/sim_dslope_sequencer.sv
`timescale 1ns/1ps
module sim_dslope_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int AZ_L  = 11;
  localparam int INT_L = 40;
  localparam int DE_L  = 44;
  localparam int ZI_L  = 30;
  localparam int RW    = 14;
  localparam int CYC   = AZ_L + INT_L + DE_L + ZI_L;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    rate_code = 3'b011;
  logic          xtal_4m = 1'b0;
  logic          line_60hz = 1'b1;
  logic          cmp_neg = 1'b0;
  logic          sw_az, sw_int, sw_ref_pos, sw_ref_neg, sw_zi;
  logic [RW-1:0] result_mag;
  logic          result_neg, overrange, eoc;

  int checks = 0;
  int fails  = 0;
  int vin    = 7;
  int integ  = 0;
  int m_t    = 0;
  int m_div  = 48;
  int exp_mag = 0;
  bit exp_neg = 0, exp_over = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dslope_sequencer #(
    .AZ_LEN (AZ_L), .INT_LEN (INT_L), .DEINT_LEN (DE_L), .ZI_LEN (ZI_L),
    .RES_W (RW)
  ) u0 (
    .clk (clk), .rst_n (rst_n), .rate_code (rate_code), .xtal_4m (xtal_4m),
    .line_60hz (line_60hz), .cmp_neg (cmp_neg), .sw_az (sw_az),
    .sw_int (sw_int), .sw_ref_pos (sw_ref_pos), .sw_ref_neg (sw_ref_neg),
    .sw_zi (sw_zi), .result_mag (result_mag), .result_neg (result_neg),
    .overrange (overrange), .eoc (eoc)
  );

  // Clocks per count tick, tabulated independently (R3, R4, R5).
  function automatic int bench_div(input logic [2:0] c, input bit h60, input bit x4);
    if (x4) begin
      case (c)
        3'b101: return 1;   3'b100: return 2;   3'b011: return 2;
        3'b010: return 4;   3'b001: return 8;   3'b000: return 16;
        3'b110: return 40;  default: return 80;
      endcase
    end else if (h60) begin
      case (c)
        3'b101: return 3;   3'b100: return 4;   3'b011: return 5;
        3'b010: return 10;  3'b001: return 20;  3'b000: return 40;
        3'b110: return 100; default: return 200;
      endcase
    end else begin
      case (c)
        3'b101: return 3;   3'b100: return 4;   3'b011: return 6;
        3'b010: return 12;  3'b001: return 24;  3'b000: return 48;
        3'b110: return 120; default: return 240;
      endcase
    end
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, expv);
    end
  endtask

  // Behavioural integrator and hysteresis comparator.
  always @(negedge clk) begin
    if (sw_az || sw_zi) begin
      integ   = 0;
      cmp_neg = 1'b0;
    end else begin
      if (sw_int)     integ = integ + vin;
      if (sw_ref_neg) integ = integ - INT_L;
      if (sw_ref_pos) integ = integ + INT_L;
      if (integ < 0)      cmp_neg = 1'b1;
      else if (integ > 0) cmp_neg = 1'b0;
    end
  end

  // Reference timing model: clocks since cycle start and current divider (R6).
  always @(posedge clk) begin
    if (!rst_n) begin
      m_t   <= 0;
      m_div <= 48;
    end else if (m_t + 1 == CYC * m_div) begin
      m_t   <= 0;
      m_div <= bench_div(rate_code, line_60hz, xtal_4m);
    end else begin
      m_t <= m_t + 1;
    end
  end

  // Per-clock comparison away from the active edge.
  always @(negedge clk) begin
    if (!rst_n) begin
      chk(sw_az == 1'b1 && !sw_int && !sw_zi && !sw_ref_pos && !sw_ref_neg,
          "R11 switches", {sw_az, sw_int, sw_ref_pos, sw_ref_neg, sw_zi}, 16);
      chk(!eoc && result_mag == 0 && !result_neg && !overrange,
          "R11 result", result_mag, 0);
    end else if (!done) begin
      int  b1, b2, b3, k, mag;
      bit  e_az, e_int, e_de, e_zi, e_ref, e_eoc;
      b1 = AZ_L * m_div;
      b2 = (AZ_L + INT_L) * m_div;
      b3 = (AZ_L + INT_L + DE_L) * m_div;
      k  = (vin < 0) ? -vin : vin;
      e_az  = (m_t < b1);
      e_int = (m_t >= b1) && (m_t < b2);
      e_de  = (m_t >= b2) && (m_t < b3);
      e_zi  = (m_t >= b3);
      e_ref = e_de && (m_t < (AZ_L + INT_L + k + 1) * m_div);
      e_eoc = (m_t == b3);
      chk(sw_az == e_az && sw_int == e_int && sw_zi == e_zi,
          "R1 R2 R3 R4 R5 R6 window", {sw_az, sw_int, sw_zi}, {e_az, e_int, e_zi});
      chk(sw_ref_neg == (e_ref && vin >= 0) && sw_ref_pos == (e_ref && vin < 0),
          "R7 R8 reference", {sw_ref_pos, sw_ref_neg}, {e_ref && vin < 0, e_ref && vin >= 0});
      chk(eoc == e_eoc, "R10 eoc", eoc, e_eoc);
      if (e_eoc) begin
        mag      = (k >= DE_L) ? DE_L : k;
        exp_mag  = mag;
        exp_over = (k >= DE_L);
        exp_neg  = (vin < 0);
      end
      chk(result_mag == exp_mag, "R8 R9 magnitude", result_mag, exp_mag);
      chk(overrange == exp_over, "R9 overrange", overrange, exp_over);
      chk(result_neg == exp_neg, "R7 sign", result_neg, exp_neg);
    end
  end

  task automatic next_cycle(input int v, input logic [2:0] c, input bit x4, input bit h60);
    @(posedge eoc);
    @(negedge clk);
    #1;
    vin       = v;
    rate_code = c;
    xtal_4m   = x4;
    line_60hz = h60;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    next_cycle(0,   3'b101, 0, 0);  // R3 div 3, zero input
    next_cycle(-7,  3'b100, 0, 0);  // R3 div 4, negative sign
    next_cycle(43,  3'b011, 0, 1);  // R4 div 5, last in-range value
    next_cycle(44,  3'b011, 0, 0);  // R3 div 6, R9 positive saturation
    next_cycle(-50, 3'b101, 1, 1);  // R5 div 1, R9 negative saturation
    next_cycle(1,   3'b100, 1, 0);  // R5 div 2
    next_cycle(-1,  3'b011, 1, 1);  // R5 60 Hz bit ignored, div 2
    next_cycle(20,  3'b110, 1, 0);  // R5 div 40
    next_cycle(-43, 3'b111, 0, 1);  // R4 div 200
    next_cycle(5,   3'b000, 0, 1);  // R4 div 40
    @(posedge eoc);
    @(negedge clk);
    #1;
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule